// File: doc/BRIEF.md
# Storage Operand Address Former

This block turns the operand fields of an instruction into a checked 24-bit storage address. It reads a base value and an index value from the general register file, adds them to an unsigned 12-bit displacement, and registers the sum one clock after a valid request. It also works out how long the instruction is from the opcode byte. Two checks run on the result:

- an alignment check that depends on the operand size;
- a bounds check that covers every byte of the operand against the storage capacity installed in the system.

The register file is outside the block. The block presents the two selector fields on its read-select outputs and uses the data returned in the same cycle. A selector field of zero means "no register", so that operand contributes nothing. Only the low 24 bits of a register take part in the sum. The sum wraps silently from the top of the address space back to zero.

Top module: `oag_top`

## Requirements
- R1: One cycle after a clock edge with `in_valid` high, `out_valid` is high and `out_addr` equals (base value + index value + displacement) modulo 2^24. One cycle after an edge with `in_valid` low, `out_valid` is low.
- R2: A sum that passes 0xFFFFFF wraps to the low addresses. The wrap alone raises no flag.
- R3: A base or index selector equal to 0 contributes zero, whatever register 0 holds.
- R4: Only bits 23:0 of a register value are used. Bits 31:24 have no effect on `out_addr`.
- R5: `out_ilen` gives the instruction length in halfwords from opcode bits 7:6 (the two leftmost bits): 00 gives 1, 01 and 10 give 2, 11 gives 3.
- R6: `in_size` encodes the operand length as 0=1 byte, 1=2 bytes, 2=4 bytes, 3=8 bytes. `out_spec_err` is high when the address has any of its low `in_size` bits set. A 1-byte operand never raises it.
- R7: `out_addr_err` is high when any byte of the operand (address up to address+length-1) lies at or above `in_limit`. A limit of 2^24 or more means full storage, and then no address is out of range, even when the operand wraps past the top.
- R8: When both conditions hold, both flags are high in the same cycle.
- R9: While reset is high and in the cycle after it, `out_valid`, `out_spec_err` and `out_addr_err` are low.
- R10: `base_rd_sel` and `index_rd_sel` follow `in_base` and `in_index` in the same cycle. Both flags are low whenever `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request valid |
| in_opcode | input | 8 | Opcode byte |
| in_base | input | 4 | Base register selector |
| in_index | input | 4 | Index register selector |
| in_disp | input | 12 | Unsigned displacement |
| in_size | input | 2 | Operand length code |
| in_limit | input | 25 | Installed storage size in bytes |
| base_rd_sel | output | 4 | Register file read select, base |
| base_rd_data | input | 32 | Register file read data, base |
| index_rd_sel | output | 4 | Register file read select, index |
| index_rd_data | input | 32 | Register file read data, index |
| out_valid | output | 1 | Result valid |
| out_addr | output | 24 | Effective address |
| out_ilen | output | 2 | Instruction length in halfwords |
| out_spec_err | output | 1 | Misaligned operand |
| out_addr_err | output | 1 | Operand beyond installed storage |

## Verification
The bench builds the block with its default parameters: a 24-bit address, a 12-bit displacement and 32-bit registers. The limit port is 25 bits wide, so the full-storage value of exactly 2^24 can be driven. This lets the bench exercise an operand that crosses the top of storage under a full limit, where no range flag is expected, and the same operand under a limit one byte short, where the flag is expected. Register values with non-zero upper bytes and a non-zero register 0 exercise the field-zero and truncation rules.

// File: rtl/oag_pkg.sv
package oag_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_DBL  = 2'd3
    } opnd_size_e;

    typedef enum logic [1:0] {
        ILEN_NONE  = 2'd0,
        ILEN_ONE   = 2'd1,
        ILEN_TWO   = 2'd2,
        ILEN_THREE = 2'd3
    } ilen_e;

    typedef struct packed {
        logic misalign;
        logic out_of_range;
    } fault_t;

    // Instruction length in halfwords from the two leftmost opcode bits.
    function automatic ilen_e ilen_from_top(input logic [1:0] top);
        ilen_e l;
        case (top)
            2'b00:   l = ILEN_ONE;
            2'b11:   l = ILEN_THREE;
            default: l = ILEN_TWO;
        endcase
        return l;
    endfunction

    // Mask of low address bits that must be zero for an operand size.
    function automatic logic [2:0] align_mask(input opnd_size_e s);
        logic [2:0] m;
        case (s)
            SZ_HALF: m = 3'b001;
            SZ_WORD: m = 3'b011;
            SZ_DBL:  m = 3'b111;
            default: m = 3'b000;
        endcase
        return m;
    endfunction

    // Operand length minus one, in bytes.
    function automatic logic [2:0] last_offset(input opnd_size_e s);
        logic [2:0] o;
        case (s)
            SZ_HALF: o = 3'd1;
            SZ_WORD: o = 3'd3;
            SZ_DBL:  o = 3'd7;
            default: o = 3'd0;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/oag_operand_gate.sv
module oag_operand_gate #(
    parameter int SEL_W  = 4,
    parameter int REG_W  = 32,
    parameter int ADDR_W = 24
) (
    input  logic [SEL_W-1:0]  sel,
    input  logic [REG_W-1:0]  reg_data,
    output logic [ADDR_W-1:0] value
);
    // Selector zero means "no register"; otherwise keep the address-wide low part.
    always_comb begin
        if (sel == '0)
            value = '0;
        else
            value = reg_data[ADDR_W-1:0];
    end
endmodule

// File: rtl/oag_sum.sv
module oag_sum #(
    parameter int ADDR_W = 24,
    parameter int DISP_W = 12
) (
    input  logic [ADDR_W-1:0] base_val,
    input  logic [ADDR_W-1:0] index_val,
    input  logic [DISP_W-1:0] disp,
    output logic [ADDR_W-1:0] sum
);
    localparam int PAD_W = ADDR_W - DISP_W;

    logic [ADDR_W-1:0] disp_ext;

    always_comb begin
        disp_ext = {{PAD_W{1'b0}}, disp};
        // Result width truncates: the sum wraps modulo 2^ADDR_W.
        sum      = base_val + index_val + disp_ext;
    end
endmodule

// File: rtl/oag_check.sv
module oag_check
    import oag_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic [ADDR_W-1:0] addr,
    input  opnd_size_e        size,
    input  logic [ADDR_W:0]   limit,
    output fault_t            fault
);
    localparam int EXT_W = ADDR_W + 1;

    logic [EXT_W-1:0]  end_ext;
    logic [ADDR_W-1:0] last_byte;

    always_comb begin
        fault.misalign = |(addr[2:0] & align_mask(size));

        end_ext = {1'b0, addr} + {{(EXT_W-3){1'b0}}, last_offset(size)};
        // A wrapped operand still occupies the topmost byte.
        if (end_ext[ADDR_W])
            last_byte = '1;
        else
            last_byte = end_ext[ADDR_W-1:0];

        fault.out_of_range = ({1'b0, last_byte} >= limit);
    end
endmodule

// File: rtl/oag_top.sv
module oag_top
    import oag_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DISP_W = 12,
    parameter int REG_W  = 32,
    parameter int SEL_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [7:0]        in_opcode,
    input  logic [SEL_W-1:0]  in_base,
    input  logic [SEL_W-1:0]  in_index,
    input  logic [DISP_W-1:0] in_disp,
    input  logic [1:0]        in_size,
    input  logic [ADDR_W:0]   in_limit,
    output logic [SEL_W-1:0]  base_rd_sel,
    input  logic [REG_W-1:0]  base_rd_data,
    output logic [SEL_W-1:0]  index_rd_sel,
    input  logic [REG_W-1:0]  index_rd_data,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr,
    output logic [1:0]        out_ilen,
    output logic              out_spec_err,
    output logic              out_addr_err
);
    localparam int NOPND = 2;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        ilen_e             ilen;
        fault_t            fault;
    } result_t;

    logic [SEL_W-1:0]  sel_arr  [NOPND];
    logic [REG_W-1:0]  data_arr [NOPND];
    logic [ADDR_W-1:0] val_arr  [NOPND];
    logic [ADDR_W-1:0] sum;
    fault_t            fault_now;
    result_t           res_d, res_q;

    assign base_rd_sel  = in_base;
    assign index_rd_sel = in_index;

    always_comb begin
        sel_arr[0]  = in_base;
        sel_arr[1]  = in_index;
        data_arr[0] = base_rd_data;
        data_arr[1] = index_rd_data;
    end

    for (genvar g = 0; g < NOPND; g++) begin : g_opnd
        oag_operand_gate #(
            .SEL_W (SEL_W),
            .REG_W (REG_W),
            .ADDR_W(ADDR_W)
        ) u_gate (
            .sel     (sel_arr[g]),
            .reg_data(data_arr[g]),
            .value   (val_arr[g])
        );
    end

    oag_sum #(
        .ADDR_W(ADDR_W),
        .DISP_W(DISP_W)
    ) u_sum (
        .base_val (val_arr[0]),
        .index_val(val_arr[1]),
        .disp     (in_disp),
        .sum      (sum)
    );

    oag_check #(
        .ADDR_W(ADDR_W)
    ) u_check (
        .addr (sum),
        .size (opnd_size_e'(in_size)),
        .limit(in_limit),
        .fault(fault_now)
    );

    always_comb begin
        res_d.valid = in_valid;
        res_d.addr  = sum;
        res_d.ilen  = ilen_from_top(in_opcode[7:6]);
        res_d.fault = in_valid ? fault_now : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else begin
            res_q.valid <= res_d.valid;
            res_q.fault <= res_d.fault;
            if (in_valid) begin
                res_q.addr <= res_d.addr;
                res_q.ilen <= res_d.ilen;
            end
        end
    end

    assign out_valid    = res_q.valid;
    assign out_addr     = res_q.addr;
    assign out_ilen     = res_q.ilen;
    assign out_spec_err = res_q.fault.misalign;
    assign out_addr_err = res_q.fault.out_of_range;

endmodule

// File: rtl/oag_checker.sv
module oag_checker #(
    parameter int ADDR_W = 24,
    parameter int DISP_W = 12,
    parameter int SEL_W  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [SEL_W-1:0]  in_base,
    input logic [SEL_W-1:0]  in_index,
    input logic [DISP_W-1:0] in_disp,
    input logic [1:0]        in_size,
    input logic [ADDR_W:0]   in_limit,
    input logic              out_valid,
    input logic [ADDR_W-1:0] out_addr,
    input logic [1:0]        out_ilen,
    input logic              out_spec_err,
    input logic              out_addr_err
);
    localparam logic [ADDR_W:0] FULL = {1'b1, {ADDR_W{1'b0}}};

    a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r1_idle_follows: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    a_r3_no_regs_gives_disp: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_base == '0 && in_index == '0)
        |=> out_addr == {{(ADDR_W-DISP_W){1'b0}}, $past(in_disp)});

    a_r5_ilen_nonzero: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_ilen != 2'd0);

    a_r6_byte_never_spec: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_size == 2'd0) |=> !out_spec_err);

    a_r6_dbl_alignment: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_size == 2'd3) |=> out_spec_err == (out_addr[2:0] != 3'd0));

    a_r7_full_limit_clean: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_limit >= FULL) |=> !out_addr_err);

    a_r10_flags_quiet_idle: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (!out_spec_err && !out_addr_err));

endmodule

bind oag_top oag_checker #(
    .ADDR_W(ADDR_W),
    .DISP_W(DISP_W),
    .SEL_W (SEL_W)
) u_oag_checker (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_base     (in_base),
    .in_index    (in_index),
    .in_disp     (in_disp),
    .in_size     (in_size),
    .in_limit    (in_limit),
    .out_valid   (out_valid),
    .out_addr    (out_addr),
    .out_ilen    (out_ilen),
    .out_spec_err(out_spec_err),
    .out_addr_err(out_addr_err)
);

// File: tb/tb_oag_top.sv
`timescale 1ns/1ps
module tb_oag_top;
    localparam logic [24:0] FULL = 25'h1000000;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [7:0]  in_opcode;
    logic [3:0]  in_base, in_index;
    logic [11:0] in_disp;
    logic [1:0]  in_size;
    logic [24:0] in_limit;
    logic [3:0]  base_rd_sel, index_rd_sel;
    logic [31:0] base_rd_data, index_rd_data;
    logic        out_valid;
    logic [23:0] out_addr;
    logic [1:0]  out_ilen;
    logic        out_spec_err, out_addr_err;

    logic [31:0] rf [16];
    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    always_comb begin
        base_rd_data  = rf[base_rd_sel];
        index_rd_data = rf[index_rd_sel];
    end

    oag_top dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_opcode(in_opcode),
        .in_base(in_base), .in_index(in_index), .in_disp(in_disp),
        .in_size(in_size), .in_limit(in_limit),
        .base_rd_sel(base_rd_sel), .base_rd_data(base_rd_data),
        .index_rd_sel(index_rd_sel), .index_rd_data(index_rd_data),
        .out_valid(out_valid), .out_addr(out_addr), .out_ilen(out_ilen),
        .out_spec_err(out_spec_err), .out_addr_err(out_addr_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Drive one request at a falling edge; return after the result edge, at the next falling edge.
    task automatic issue(input logic [7:0] op, input logic [3:0] b, input logic [3:0] x,
                         input logic [11:0] d, input logic [1:0] sz, input logic [24:0] lim);
        @(negedge clk);
        in_valid  = 1'b1;
        in_opcode = op;
        in_base   = b;
        in_index  = x;
        in_disp   = d;
        in_size   = sz;
        in_limit  = lim;
        #1;
        chk("R10 base select", {28'd0, base_rd_sel}, {28'd0, b});
        chk("R10 index select", {28'd0, index_rd_sel}, {28'd0, x});
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_out(input string tag, input logic [23:0] a, input logic sp, input logic ae);
        chk({tag, " valid"}, {31'd0, out_valid}, 32'd1);
        chk({tag, " addr"}, {8'd0, out_addr}, {8'd0, a});
        chk({tag, " spec"}, {31'd0, out_spec_err}, {31'd0, sp});
        chk({tag, " range"}, {31'd0, out_addr_err}, {31'd0, ae});
    endtask

    task automatic t_reset;
        chk("R9 valid in reset", {31'd0, out_valid}, 32'd0);
        chk("R9 spec in reset", {31'd0, out_spec_err}, 32'd0);
        chk("R9 range in reset", {31'd0, out_addr_err}, 32'd0);
    endtask

    task automatic t_basic;
        rf[3] = 32'h0001_0000;
        rf[5] = 32'h0000_0200;
        issue(8'h5A, 4'd3, 4'd5, 12'h034, 2'd0, FULL);
        expect_out("R1 base+index+disp", 24'h010234, 1'b0, 1'b0);
    endtask

    task automatic t_zero_fields;
        rf[0] = 32'h0012_3456;
        rf[2] = 32'h0000_0040;
        issue(8'h1A, 4'd0, 4'd0, 12'h345, 2'd0, FULL);
        expect_out("R3 both fields zero", 24'h000345, 1'b0, 1'b0);
        issue(8'h1A, 4'd0, 4'd2, 12'h001, 2'd0, FULL);
        expect_out("R3 base field zero", 24'h000041, 1'b0, 1'b0);
        issue(8'h1A, 4'd2, 4'd0, 12'h001, 2'd0, FULL);
        expect_out("R3 index field zero", 24'h000041, 1'b0, 1'b0);
    endtask

    task automatic t_high_bits;
        rf[10] = 32'hAB00_0100;
        issue(8'h1A, 4'd10, 4'd0, 12'h010, 2'd0, FULL);
        expect_out("R4 upper byte ignored", 24'h000110, 1'b0, 1'b0);
    endtask

    task automatic t_wrap;
        rf[8] = 32'h00FF_FFF0;
        rf[9] = 32'h00FF_FFFF;
        issue(8'h1A, 4'd8, 4'd0, 12'h020, 2'd0, FULL);
        expect_out("R2 wrap past top", 24'h000010, 1'b0, 1'b0);
        issue(8'h1A, 4'd8, 4'd9, 12'h001, 2'd0, FULL);
        expect_out("R2 double wrap", 24'hFFFFF0, 1'b0, 1'b0);
    endtask

    task automatic t_ilen;
        issue(8'h1A, 4'd0, 4'd0, 12'h0, 2'd0, FULL);
        chk("R5 opcode 00", {30'd0, out_ilen}, 32'd1);
        issue(8'h5A, 4'd0, 4'd0, 12'h0, 2'd0, FULL);
        chk("R5 opcode 01", {30'd0, out_ilen}, 32'd2);
        issue(8'h9A, 4'd0, 4'd0, 12'h0, 2'd0, FULL);
        chk("R5 opcode 10", {30'd0, out_ilen}, 32'd2);
        issue(8'hDA, 4'd0, 4'd0, 12'h0, 2'd0, FULL);
        chk("R5 opcode 11", {30'd0, out_ilen}, 32'd3);
    endtask

    task automatic t_align;
        rf[1] = 32'h0000_2000;
        issue(8'h5A, 4'd1, 4'd0, 12'h003, 2'd0, FULL);
        expect_out("R6 byte odd", 24'h002003, 1'b0, 1'b0);
        issue(8'h5A, 4'd1, 4'd0, 12'h002, 2'd1, FULL);
        expect_out("R6 half aligned", 24'h002002, 1'b0, 1'b0);
        issue(8'h5A, 4'd1, 4'd0, 12'h001, 2'd1, FULL);
        expect_out("R6 half odd", 24'h002001, 1'b1, 1'b0);
        issue(8'h5A, 4'd1, 4'd0, 12'h006, 2'd2, FULL);
        expect_out("R6 word off 2", 24'h002006, 1'b1, 1'b0);
        issue(8'h5A, 4'd1, 4'd0, 12'h004, 2'd2, FULL);
        expect_out("R6 word aligned", 24'h002004, 1'b0, 1'b0);
        issue(8'h5A, 4'd1, 4'd0, 12'h004, 2'd3, FULL);
        expect_out("R6 dbl off 4", 24'h002004, 1'b1, 1'b0);
        issue(8'h5A, 4'd1, 4'd0, 12'h008, 2'd3, FULL);
        expect_out("R6 dbl aligned", 24'h002008, 1'b0, 1'b0);
    endtask

    task automatic t_range;
        issue(8'h5A, 4'd0, 4'd0, 12'h7FC, 2'd2, 25'h800);
        expect_out("R7 word ends at limit-1", 24'h0007FC, 1'b0, 1'b0);
        issue(8'h5A, 4'd0, 4'd0, 12'h7F8, 2'd3, 25'h800);
        expect_out("R7 dbl ends at limit-1", 24'h0007F8, 1'b0, 1'b0);
        issue(8'h5A, 4'd0, 4'd0, 12'h7FE, 2'd2, 25'h800);
        expect_out("R7 word tail beyond", 24'h0007FE, 1'b1, 1'b1);
        issue(8'h5A, 4'd0, 4'd0, 12'h800, 2'd0, 25'h800);
        expect_out("R7 byte at limit", 24'h000800, 1'b0, 1'b1);
        rf[7] = 32'h00FF_FFFE;
        issue(8'h5A, 4'd7, 4'd0, 12'h000, 2'd2, FULL);
        expect_out("R7 wrap under full limit", 24'hFFFFFE, 1'b1, 1'b0);
        issue(8'h5A, 4'd7, 4'd0, 12'h000, 2'd1, 25'hFFFFFF);
        expect_out("R7 top byte beyond", 24'hFFFFFE, 1'b0, 1'b1);
    endtask

    task automatic t_both;
        issue(8'h5A, 4'd0, 4'd0, 12'h102, 2'd3, 25'h100);
        expect_out("R8 both flags", 24'h000102, 1'b1, 1'b1);
    endtask

    task automatic t_idle;
        @(negedge clk);
        in_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R1 valid drops", {31'd0, out_valid}, 32'd0);
        chk("R10 spec quiet", {31'd0, out_spec_err}, 32'd0);
        chk("R10 range quiet", {31'd0, out_addr_err}, 32'd0);
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) rf[i] = 32'h0;
        rst = 1'b1;
        in_valid = 1'b0;
        in_opcode = '0;
        in_base = '0;
        in_index = '0;
        in_disp = '0;
        in_size = '0;
        in_limit = FULL;
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset;
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_basic;
        t_zero_fields;
        t_high_bits;
        t_wrap;
        t_ilen;
        t_align;
        t_range;
        t_both;
        t_idle;
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule